// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces and checks the single even-parity bit that covers the 32-bit address/data bus and the 4-bit command/byte-enable bus of a PCI agent. Parity on PCI runs one clock behind the data it covers. The block therefore computes parity every clock and registers it, so that the bit is ready in the following clock. It also works out from the phase (address, read data or write data) and from the agent's role (master or target) which side owns the parity line in that following clock.

When this agent owns the line, the block enables its parity output and drives the bit for the previous clock's bus contents. When the other agent owns it, the block samples the incoming parity bit one clock after the qualifying event and compares it with the value it stored. A mismatch raises a one-clock error strobe. The strobe is marked as an address-parity error or a data-parity error. The qualifying data event is a clock in which TRDY is asserted for reads, and a clock in which IRDY is asserted for writes. Clocks without that handshake (wait states) are neither driven nor checked.

Top module: `pci_parity_unit`

## Requirements
- R1: Whenever `par_oe` is 1, the ones in the previous clock's `ad`, `cbe` and the current `par_out` add up to an even count.
- R2: In the master role (`role_tgt`=0), a clock with `addr_ph`=1 is followed by a clock with `par_oe`=1.
- R3: The parity output is enabled in the clock after a data clock (`data_ph`=1, `addr_ph`=0) that this agent owns. For a master, that is a write (`dir_rd`=0) with `irdy`=1. For a target (`role_tgt`=1), that is a read (`dir_rd`=1) with `trdy`=1.
- R4: `par_oe` is 0 in every clock that does not follow an owned event. This covers wait states without the qualifying handshake, target writes, master reads, a target's address phase, and idle clocks.
- R5: For a data clock the other agent owns (target write with `irdy`=1, or master read with `trdy`=1), `par_in` is sampled in the next clock. If it differs from the XOR of the data clock's `ad` and `cbe`, `err_data` is 1 for exactly the clock after that sample.
- R6: In the target role, `par_in` is checked in the clock after `addr_ph`=1. A mismatch raises `err_addr`, not `err_data`, one clock after the sample. Data clocks that lack the handshake are never checked, whatever `par_in` holds.
- R7: A `par_in` that matches the stored parity raises no error strobe.
- R8: While `rst_n` is 0, and in the first clock after reset, `par_oe`, `par_out`, `err_addr` and `err_data` are all 0.
- R9: `par_out` is 0 whenever `par_oe` is 0, and at most one error strobe is high in any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| role_tgt | input | 1 | 1: this agent is the target of the transaction; 0: it is the master |
| addr_ph | input | 1 | Current clock is the address phase |
| data_ph | input | 1 | Current clock lies in a data phase |
| dir_rd | input | 1 | Transaction direction: 1 read, 0 write |
| irdy | input | 1 | Initiator-ready handshake, active high |
| trdy | input | 1 | Target-ready handshake, active high |
| ad | input | 32 | Address/data bus contents this clock |
| cbe | input | 4 | Command/byte-enable bus contents this clock |
| par_in | input | 1 | Parity bit received from the bus |
| par_out | output | 1 | Parity bit driven by this agent |
| par_oe | output | 1 | Output enable for `par_out` |
| err_addr | output | 1 | One-clock strobe: address parity mismatch |
| err_data | output | 1 | One-clock strobe: data parity mismatch |

## Verification
The bench goes after the one-clock lag. A design that compared `par_in` with parity from the same clock, or that drove parity in the event clock itself, would miss the expected values on almost every driven or checked phase.

It also exercises direction and role swaps. A decoder with read and write swapped would drive while it should listen, and would report errors against its own data.

Wait states carry deliberately wrong `par_in` values. A checker that ignored the handshake would raise spurious strobes on them.

Address and data mismatches are both forced. A design that mixed up the two strobe tags, or stretched a strobe past one clock, is caught by the clock-exact scoreboard.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    // Register set kept by the parity unit between clocks.
    typedef struct packed {
        logic par;      // parity driven onto the bus
        logic oe;       // drive enable for the parity line
        logic chk_a;    // a received address parity is due this clock
        logic chk_d;    // a received data parity is due this clock
        logic ref_par;  // parity of the previous clock's bus contents
        logic err_a;    // address parity mismatch strobe
        logic err_d;    // data parity mismatch strobe
    } par_state_t;

    localparam par_state_t PAR_STATE_RST = '{default: 1'b0};

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
    parameter int W = 36
) (
    input  logic [W-1:0] vec,
    output logic         odd
);
    localparam int LVL = (W > 1) ? $clog2(W) : 1;
    localparam int N   = 1 << LVL;

    // Heap-ordered XOR tree: leaves at [N .. 2N-1], root at [1].
    logic [2*N-1:0] node;

    assign node[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_leaf
            if (i < W) begin : g_used
                assign node[N+i] = vec[i];
            end else begin : g_pad
                assign node[N+i] = 1'b0;
            end
        end
        for (genvar j = 1; j < N; j++) begin : g_xor
            assign node[j] = node[2*j] ^ node[2*j+1];
        end
    endgenerate

    assign odd = node[1];

endmodule

// File: rtl/pci_par_decode.sv
module pci_par_decode (
    input  logic role_tgt,
    input  logic addr_ph,
    input  logic data_ph,
    input  logic dir_rd,
    input  logic irdy,
    input  logic trdy,
    output logic drive,
    output logic chk_addr,
    output logic chk_data
);
    logic xfer;
    logic data_ev;
    logic ours_data;

    always_comb begin
        // A data clock counts once the side that supplies the data is ready.
        xfer      = data_ph & (dir_rd ? trdy : irdy);
        data_ev   = xfer & ~addr_ph;
        // The data source owns parity: the target on reads, the master on writes.
        ours_data = role_tgt ? dir_rd : ~dir_rd;
        drive     = (addr_ph & ~role_tgt) | (data_ev & ours_data);
        chk_addr  = addr_ph & role_tgt;
        chk_data  = data_ev & ~ours_data;
    end

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
    parameter int AD_W = 32,
    parameter int BE_W = AD_W / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            role_tgt,
    input  logic            addr_ph,
    input  logic            data_ph,
    input  logic            dir_rd,
    input  logic            irdy,
    input  logic            trdy,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            par_in,
    output logic            par_out,
    output logic            par_oe,
    output logic            err_addr,
    output logic            err_data
);
    import pci_par_pkg::*;

    localparam int COV_W = AD_W + BE_W;

    logic             bus_odd;
    logic             drive;
    logic             chk_addr;
    logic             chk_data;
    logic             rx_bad;
    par_state_t       s_d;
    par_state_t       s_q;

    pci_par_tree #(.W(COV_W)) u_tree (
        .vec ({cbe, ad}),
        .odd (bus_odd)
    );

    pci_par_decode u_dec (
        .role_tgt (role_tgt),
        .addr_ph  (addr_ph),
        .data_ph  (data_ph),
        .dir_rd   (dir_rd),
        .irdy     (irdy),
        .trdy     (trdy),
        .drive    (drive),
        .chk_addr (chk_addr),
        .chk_data (chk_data)
    );

    always_comb begin
        s_d         = s_q;
        rx_bad      = par_in ^ s_q.ref_par;
        s_d.oe      = drive;
        s_d.par     = drive & bus_odd;
        s_d.chk_a   = chk_addr;
        s_d.chk_d   = chk_data;
        s_d.ref_par = bus_odd;
        s_d.err_a   = s_q.chk_a & rx_bad;
        s_d.err_d   = s_q.chk_d & rx_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= PAR_STATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign par_out  = s_q.par;
    assign par_oe   = s_q.oe;
    assign err_addr = s_q.err_a;
    assign err_data = s_q.err_d;

endmodule

// File: rtl/pci_parity_unit_sva.sv
module pci_parity_unit_sva #(
    parameter int AD_W = 32,
    parameter int BE_W = AD_W / 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            role_tgt,
    input logic            addr_ph,
    input logic            data_ph,
    input logic            dir_rd,
    input logic            irdy,
    input logic            trdy,
    input logic [AD_W-1:0] ad,
    input logic [BE_W-1:0] cbe,
    input logic            par_in,
    input logic            par_out,
    input logic            par_oe,
    input logic            err_addr,
    input logic            err_data
);
    // R8: quiet outputs while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r8_reset_quiet: assert (!par_oe && !par_out && !err_addr && !err_data)
                else $error("a_r8_reset_quiet");
        end
    end

    // R1: driven parity makes the covered ones count even
    a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> (^{$past(ad), $past(cbe), par_out}) == 1'b0);

    // R2: master address phase is followed by a driven parity clock
    a_r2_master_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ph && !role_tgt) |=> par_oe);

    // R3: target read transfer is followed by a driven parity clock
    a_r3_target_read: assert property (@(posedge clk) disable iff (!rst_n)
        (role_tgt && data_ph && dir_rd && trdy && !addr_ph) |=> par_oe);

    // R4: a target never drives parity after a write clock
    a_r4_target_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (role_tgt && !dir_rd && !addr_ph) |=> !par_oe);

    // R5: a data error strobe is backed by a real mismatch two clocks back
    a_r5_data_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_data |-> ($past(par_in) != $past(^{ad, cbe}, 2)));

    // R6: an address error strobe follows a target address phase
    a_r6_addr_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_addr |-> ($past(addr_ph, 2) && $past(role_tgt, 2)));

    // R9: idle output low, strobes exclusive
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !par_oe |-> !par_out);

    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_addr, err_data}));

endmodule

bind pci_parity_unit pci_parity_unit_sva #(.AD_W(AD_W), .BE_W(BE_W)) u_sva (.*);

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;

    typedef struct {
        logic  oe;
        logic  par;
        logic  ea;
        logic  ed;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        role_tgt = 1'b0;
    logic        addr_ph = 1'b0;
    logic        data_ph = 1'b0;
    logic        dir_rd = 1'b0;
    logic        irdy = 1'b0;
    logic        trdy = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        par_in = 1'b0;
    logic        par_out;
    logic        par_oe;
    logic        err_addr;
    logic        err_data;

    int   n_vec  = 0;
    int   n_fail = 0;
    exp_t sb_q[$];

    // Reference state from the previous applied clock
    logic prv_ca = 1'b0;
    logic prv_cd = 1'b0;
    logic prv_p  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pci_parity_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .role_tgt (role_tgt),
        .addr_ph  (addr_ph),
        .data_ph  (data_ph),
        .dir_rd   (dir_rd),
        .irdy     (irdy),
        .trdy     (trdy),
        .ad       (ad),
        .cbe      (cbe),
        .par_in   (par_in),
        .par_out  (par_out),
        .par_oe   (par_oe),
        .err_addr (err_addr),
        .err_data (err_data)
    );

    function automatic logic odd36(input logic [31:0] a, input logic [3:0] c);
        return ^{a, c};
    endfunction

    // Driver: applies one clock of stimulus and queues what must follow it
    task automatic apply(input logic t, input logic ap, input logic dp, input logic rd,
                         input logic ir, input logic tr, input logic [31:0] a,
                         input logic [3:0] c, input logic pin, input string tag);
        logic xf, ev_d, mine, ca, cd, p;
        exp_t e;
        @(negedge clk);
        role_tgt = t; addr_ph = ap; data_ph = dp; dir_rd = rd;
        irdy = ir; trdy = tr; ad = a; cbe = c; par_in = pin;
        xf   = dp & (rd ? tr : ir);
        ev_d = xf & ~ap;
        mine = t ? (ev_d & rd) : (ap | (ev_d & ~rd));
        ca   = ap & t;
        cd   = ev_d & ~mine;
        p    = odd36(a, c);
        e.oe  = mine;
        e.par = mine & p;
        e.ea  = prv_ca & (pin != prv_p);
        e.ed  = prv_cd & (pin != prv_p);
        e.tag = tag;
        sb_q.push_back(e);
        prv_ca = ca; prv_cd = cd; prv_p = p;
    endtask

    task automatic idle(input logic pin, input string tag);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'h0, pin, tag);
    endtask

    // Monitor: compares outputs after each edge that follows an applied clock
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic bad;
                e = sb_q.pop_front();
                n_vec++;
                bad = 1'b0;
                if (par_oe !== e.oe) begin
                    $display("FAIL %s par_oe: got %0b exp %0b", e.tag, par_oe, e.oe);
                    bad = 1'b1;
                end
                if (par_out !== e.par) begin
                    $display("FAIL R1 (%s) par_out: got %0b exp %0b", e.tag, par_out, e.par);
                    bad = 1'b1;
                end
                if (err_addr !== e.ea) begin
                    $display("FAIL R6 (%s) err_addr: got %0b exp %0b", e.tag, err_addr, e.ea);
                    bad = 1'b1;
                end
                if (err_data !== e.ed) begin
                    $display("FAIL R5 (%s) err_data: got %0b exp %0b", e.tag, err_data, e.ed);
                    bad = 1'b1;
                end
                if (bad) n_fail++;
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        p;

        // R8: reset state
        ad = 32'hFFFF_FFFF; addr_ph = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        n_vec++;
        if (par_oe !== 1'b0 || par_out !== 1'b0 || err_addr !== 1'b0 || err_data !== 1'b0) begin
            $display("FAIL R8 reset: got %0b%0b%0b%0b exp 0000", par_oe, par_out, err_addr, err_data);
            n_fail++;
        end
        @(negedge clk);
        addr_ph = 1'b0; ad = '0;
        rst_n = 1'b1;
        idle(1'b0, "R8");

        // Master: address, write transfer, write wait state
        apply(0, 1, 0, 0, 0, 0, 32'h1234_5678, 4'h7, 0, "R2");
        apply(0, 0, 1, 0, 1, 0, 32'hDEAD_BEEF, 4'h0, 0, "R3");
        apply(0, 0, 1, 0, 0, 0, 32'h0000_0001, 4'h0, 1, "R4");
        apply(0, 0, 1, 0, 1, 0, 32'h0000_0001, 4'hE, 0, "R3");

        // Master read: wrong then right received parity
        d = 32'hA5A5_0F0F; p = odd36(d, 4'h3);
        apply(0, 0, 1, 1, 1, 1, d, 4'h3, 0, "R4");
        apply(0, 0, 1, 1, 1, 0, 32'h0, 4'h0, ~p, "R5");
        apply(0, 0, 1, 1, 1, 1, d, 4'h1, 0, "R4");
        idle(odd36(d, 4'h1), "R7");
        idle(0, "R7");

        // Target: address parity good, then bad
        d = 32'h8000_0040; p = odd36(d, 4'h6);
        apply(1, 1, 0, 0, 0, 0, d, 4'h6, 0, "R4");
        apply(1, 0, 1, 1, 1, 0, 32'h0, 4'h0, p, "R7");
        d = 32'h0000_0300; p = odd36(d, 4'hB);
        apply(1, 1, 0, 1, 0, 0, d, 4'hB, 0, "R4");
        apply(1, 0, 1, 1, 1, 0, 32'h0, 4'h0, ~p, "R6");
        idle(0, "R6");

        // Target read: transfer drives, wait state does not
        apply(1, 0, 1, 1, 1, 1, 32'hCAFE_F00D, 4'h0, 0, "R3");
        apply(1, 0, 1, 1, 1, 0, 32'hCAFE_F00D, 4'h0, 0, "R4");
        apply(1, 0, 1, 1, 1, 1, 32'h7FFF_FFFF, 4'hF, 0, "R3");

        // Target write: wait state with bad parity is ignored, transfer is checked
        apply(1, 0, 1, 0, 0, 1, 32'h1111_1111, 4'h0, 1, "R4");
        apply(1, 0, 1, 0, 0, 1, 32'h0, 4'h0, 1, "R6");
        d = 32'h0F0F_0F0E; p = odd36(d, 4'h2);
        apply(1, 0, 1, 0, 1, 0, d, 4'h2, 0, "R4");
        apply(1, 0, 0, 0, 0, 0, 32'h0, 4'h0, ~p, "R5");
        idle(0, "R5");

        // Mixed stimulus
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r[0], (r[3:1] == 3'd0), r[4] | r[5], r[6], r[7] | r[8], r[9] | r[10],
                  $urandom, r[14:11], r[15], "R9");
        end
        repeat (3) idle(0, "R9");

        repeat (2) @(posedge clk);
        #3;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule